// File: doc/BRIEF.md
# APM Command/Status Mailbox with Callback Interrupt Routing

This block holds the two 8-bit mailbox registers that an operating system and a system-management handler use to pass information to each other. Both registers sit in I/O space at fixed addresses. The command register is at 0B2h and the status register is at 0B3h. A write stores the byte, and a read returns the stored byte. The block claims any access to these two addresses that arrives on the primary I/O port. An access marked as coming from the secondary (extended) master path is neither claimed nor acted on.

A write to the command register is an event. When the event enable is set, the event raises the management interrupt. When the callback enable is also set, the event drives a separate active-low PCI interrupt line instead. Either outcome sets a shared event status bit. That bit, and the interrupt output that was driven, stay asserted until the handler pulses the write-1-to-clear input. Onward routing of the PCI interrupt line and the bus protocol are handled outside this block.

Top module: `apm_mbox`

## Requirements
- R1: After reset, both mailbox registers read 00h, `mgmt_irq` is 0, `cb_irq_n` is 1 and `evt_sts` is 0.
- R2: A primary-port write to 0B2h or 0B3h stores `io_wdata` into that register at the next clock edge. A later primary read of the same address returns the byte on `io_rdata` in the same cycle as the read strobe.
- R3: `io_hit` is 1 in the same cycle as a read or write strobe whose address is 0B2h or 0B3h and whose `io_ext` is 0. In every other case it is 0.
- R4: An access with `io_ext`=1 is not claimed (`io_hit`=0). It returns `io_rdata`=00h and changes neither register.
- R5: A claimed write to 0B2h with `apm_irq_en`=1 and `callback_en`=0 sets `mgmt_irq` and `evt_sts` to 1 in the next cycle. `cb_irq_n` stays 1.
- R6: A claimed write to 0B2h with `apm_irq_en`=1 and `callback_en`=1 drives `cb_irq_n` to 0 and sets `evt_sts` to 1 in the next cycle. `mgmt_irq` stays 0.
- R7: With `apm_irq_en`=0, a write to 0B2h stores the byte but produces no event, whatever the value of `callback_en`.
- R8: A write to 0B3h never produces an event.
- R9: `evt_sts` and the interrupt output that was driven stay asserted until `sts_clr` is pulsed. The cycle after the pulse, `evt_sts`=0, `mgmt_irq`=0 and `cb_irq_n`=1.
- R10: If an enabled event and `sts_clr` occur in the same cycle, the event wins. Only the new event's output is asserted afterwards, with `evt_sts`=1.
- R11: When no read is claimed, `io_rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_ext | input | 1 | Access comes from the secondary master path |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; 00h when no read is claimed |
| io_hit | output | 1 | Positive decode claim |
| apm_irq_en | input | 1 | Command-write event enable |
| callback_en | input | 1 | Route events to the PCI interrupt line |
| sts_clr | input | 1 | Write-1-to-clear pulse for the event status |
| mgmt_irq | output | 1 | Management interrupt, active high, level |
| cb_irq_n | output | 1 | Callback PCI interrupt line, active low, level |
| evt_sts | output | 1 | Event status bit |

## Verification
The assertions check the following on every cycle:
- The decode never claims a secondary-path access.
- Registers stay unchanged when no write is accepted, and an accepted write lands in the addressed register.
- Each event reaches the output chosen by the callback enable.
- Status holds until it is cleared, a clear empties it, and an event beats a simultaneous clear.
- Status can rise only after a command-register write.

Only the bench scenarios show two things: the values that reads return for a particular history of writes, and that a status-register write or a disabled event really leaves every output idle across a sequence of accesses.

// File: rtl/apm_mbox_pkg.sv
package apm_mbox_pkg;
   localparam int NUM_MBOX = 2;
   localparam int IDX_W    = 1;
   localparam logic [IDX_W-1:0] CMD_IDX = 1'b0;
   localparam logic [IDX_W-1:0] STS_IDX = 1'b1;

   typedef enum logic [1:0] {
      ROUTE_IDLE = 2'b00,
      ROUTE_MGMT = 2'b01,
      ROUTE_CB   = 2'b10
   } route_e;
endpackage

// File: rtl/apm_io_decode.sv
module apm_io_decode
   import apm_mbox_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] CMD_ADDR = 'hB2,
   parameter logic [ADDR_W-1:0] STS_ADDR = 'hB3
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic              ext,
   output logic              hit,
   output logic              wr_en,
   output logic              rd_en,
   output logic              cmd_wr,
   output logic [IDX_W-1:0]  idx
);
   if (CMD_ADDR == STS_ADDR) begin : g_bad_addr
      $error("apm_io_decode: command and status addresses must differ");
   end
   if (ADDR_W < 8) begin : g_bad_width
      $error("apm_io_decode: address width too small");
   end

   logic cmd_match, sts_match, primary_access;

   always_comb begin
      cmd_match      = (addr == CMD_ADDR);
      sts_match      = (addr == STS_ADDR);
      primary_access = (wr | rd) & ~ext;
      hit            = (cmd_match | sts_match) & primary_access;
      wr_en          = hit & wr;
      rd_en          = hit & rd;
      cmd_wr         = wr_en & cmd_match;
      idx            = sts_match ? STS_IDX : CMD_IDX;
   end

   // R4: secondary-path accesses are never claimed
   always_comb begin
      p_ext_unclaimed_r4: assert (!(ext && hit));
   end
endmodule

// File: rtl/apm_mbox_regs.sv
module apm_mbox_regs
   import apm_mbox_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] RST_VAL = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   if (DATA_W < 1) begin : g_bad_data
      $error("apm_mbox_regs: data width must be positive");
   end

   logic [NUM_MBOX-1:0][DATA_W-1:0] mbox_q;

   for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mbox
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   mbox_q[i] <= RST_VAL;
         else if (wr_en && idx == IDX_W'(i))           mbox_q[i] <= wdata;
      end

      // R2: an accepted write lands in the addressed register
      p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && idx == IDX_W'(i)) |=> (mbox_q[i] == $past(wdata)));
   end

   always_comb begin
      rdata = '0;
      if (rd_en) rdata = mbox_q[idx];
   end

   // R4/R7: without an accepted write no register changes
   p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mbox_q));
endmodule

// File: rtl/apm_event_route.sv
module apm_event_route
   import apm_mbox_pkg::*;
#(
   parameter bit CB_ACT_LOW = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_wr,
   input  logic irq_en,
   input  logic cb_en,
   input  logic sts_clr,
   output logic mgmt_irq,
   output logic cb_line,
   output logic sts
);
   route_e evt_route;
   logic   mgmt_q, cb_q;

   always_comb begin
      evt_route = ROUTE_IDLE;
      if (cmd_wr && irq_en) evt_route = cb_en ? ROUTE_CB : ROUTE_MGMT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mgmt_q <= 1'b0;
         cb_q   <= 1'b0;
      end else begin
         mgmt_q <= (evt_route == ROUTE_MGMT) | (mgmt_q & ~sts_clr);
         cb_q   <= (evt_route == ROUTE_CB)   | (cb_q   & ~sts_clr);
      end
   end

   assign mgmt_irq = mgmt_q;
   assign sts      = mgmt_q | cb_q;

   if (CB_ACT_LOW) begin : g_cb_low
      assign cb_line = ~cb_q;
   end else begin : g_cb_high
      assign cb_line = cb_q;
   end

   // R5: management route
   p_mgmt_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && irq_en && !cb_en) |=> (mgmt_irq && sts));
   // R6: callback route
   p_cb_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && irq_en && cb_en) |=> (cb_q && sts && (mgmt_irq == ($past(mgmt_irq) && !$past(sts_clr)))));
   // R7: no event while disabled
   p_no_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && !sts) |=> !sts);
   // R9: status holds until cleared
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sts && !sts_clr) |=> sts);
   // R9: clear empties status
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr && !(cmd_wr && irq_en)) |=> (!sts && !mgmt_irq));
   // R10: event beats a simultaneous clear
   p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr && cmd_wr && irq_en) |=> sts);
endmodule

// File: rtl/apm_mbox.sv
module apm_mbox
   import apm_mbox_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] CMD_ADDR = 'hB2,
   parameter logic [ADDR_W-1:0] STS_ADDR = 'hB3,
   parameter logic [DATA_W-1:0] RST_VAL  = '0,
   parameter bit CB_ACT_LOW = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic              io_ext,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_hit,
   input  logic              apm_irq_en,
   input  logic              callback_en,
   input  logic              sts_clr,
   output logic              mgmt_irq,
   output logic              cb_irq_n,
   output logic              evt_sts
);
   logic             wr_en, rd_en, cmd_wr;
   logic [IDX_W-1:0] idx;

   apm_io_decode #(
      .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .STS_ADDR(STS_ADDR)
   ) u_decode (
      .addr(io_addr), .wr(io_wr), .rd(io_rd), .ext(io_ext),
      .hit(io_hit), .wr_en(wr_en), .rd_en(rd_en), .cmd_wr(cmd_wr), .idx(idx)
   );

   apm_mbox_regs #(
      .DATA_W(DATA_W), .RST_VAL(RST_VAL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .idx(idx), .wdata(io_wdata), .rdata(io_rdata)
   );

   apm_event_route #(
      .CB_ACT_LOW(CB_ACT_LOW)
   ) u_route (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .irq_en(apm_irq_en),
      .cb_en(callback_en), .sts_clr(sts_clr),
      .mgmt_irq(mgmt_irq), .cb_line(cb_irq_n), .sts(evt_sts)
   );

   // R8: status rises only after a primary write to the command address
   p_only_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_sts) |-> $past(io_wr && !io_ext && io_addr == CMD_ADDR));
   // R11: no claimed read, no data
   p_idle_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && io_hit) |-> (io_rdata == '0));
endmodule

// File: tb/apm_mbox_tb.sv
module apm_mbox_tb;
   localparam logic [15:0] A_CMD = 16'h00B2;
   localparam logic [15:0] A_STS = 16'h00B3;
   localparam int S_RDATA = 0, S_HIT = 1, S_MGMT = 2, S_CB = 3, S_STS = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;  // 125 MHz

   logic        rst_n;
   logic [15:0] io_addr;
   logic        io_wr, io_rd, io_ext, apm_irq_en, callback_en, sts_clr;
   logic [7:0]  io_wdata, io_rdata;
   logic        io_hit, mgmt_irq, cb_irq_n, evt_sts;

   apm_mbox u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_ext(io_ext), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit),
      .apm_irq_en(apm_irq_en), .callback_en(callback_en), .sts_clr(sts_clr),
      .mgmt_irq(mgmt_irq), .cb_irq_n(cb_irq_n), .evt_sts(evt_sts)
   );

   typedef struct {
      int         cyc;
      int         sig;
      logic [7:0] exp;
      string      req;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_chk = 0, n_bad = 0;
   bit   done = 0;

   // reference model
   logic [7:0] m_cmd = 8'h00, m_sts = 8'h00;
   logic       m_mgmt = 1'b0, m_cb = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] observe(int sig);
      case (sig)
         S_RDATA: return io_rdata;
         S_HIT:   return {7'd0, io_hit};
         S_MGMT:  return {7'd0, mgmt_irq};
         S_CB:    return {7'd0, cb_irq_n};
         default: return {7'd0, evt_sts};
      endcase
   endfunction

   // monitor: pops expected items due at this cycle
   exp_t mon_e;
   logic [7:0] mon_got;
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         mon_e   = q.pop_front();
         mon_got = observe(mon_e.sig);
         n_chk++;
         if (mon_got !== mon_e.exp) begin
            n_bad++;
            $display("FAIL %s sig=%0d cyc=%0d actual=%h expected=%h",
                     mon_e.req, mon_e.sig, mon_e.cyc, mon_got, mon_e.exp);
         end
      end
   end

   task automatic push(int sig, logic [7:0] exp, string req);
      q.push_back('{cyc, sig, exp, req});
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push_state(string req);
      push(S_MGMT, {7'd0, m_mgmt}, req);
      push(S_CB,   {7'd0, ~m_cb}, req);
      push(S_STS,  {7'd0, m_mgmt | m_cb}, req);
   endtask

   function automatic logic claimed(logic [15:0] a, logic ext);
      return !ext && (a == A_CMD || a == A_STS);
   endfunction

   task automatic wr(logic [15:0] a, logic [7:0] d, logic ext, string req);
      logic h;
      step();
      io_addr = a; io_wdata = d; io_wr = 1'b1; io_ext = ext;
      h = claimed(a, ext);
      push(S_HIT, {7'd0, h}, req);
      if (h) begin
         if (a == A_CMD) m_cmd = d; else m_sts = d;
         if (a == A_CMD && apm_irq_en) begin
            if (callback_en) m_cb = 1'b1; else m_mgmt = 1'b1;
         end
      end
      step();
      io_wr = 1'b0; io_ext = 1'b0;
      push_state(req);
   endtask

   task automatic rd(logic [15:0] a, logic ext, string req);
      logic h;
      step();
      io_addr = a; io_rd = 1'b1; io_ext = ext;
      h = claimed(a, ext);
      push(S_HIT, {7'd0, h}, req);
      push(S_RDATA, h ? ((a == A_CMD) ? m_cmd : m_sts) : 8'h00, req);
      step();
      io_rd = 1'b0; io_ext = 1'b0;
   endtask

   task automatic clr(logic with_wr, logic [7:0] d, string req);
      logic evt;
      step();
      sts_clr = 1'b1;
      if (with_wr) begin
         io_addr = A_CMD; io_wdata = d; io_wr = 1'b1;
         m_cmd = d;
      end
      evt = with_wr && apm_irq_en;
      m_mgmt = evt && !callback_en;
      m_cb   = evt && callback_en;
      step();
      sts_clr = 1'b0; io_wr = 1'b0;
      push_state(req);
   endtask

   task automatic idle(int n, string req);
      repeat (n) step();
      push_state(req);
   endtask

   initial begin
      rst_n = 1'b0; io_addr = '0; io_wr = 0; io_rd = 0; io_ext = 0;
      io_wdata = '0; apm_irq_en = 0; callback_en = 0; sts_clr = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      push_state("R1");
      push(S_RDATA, 8'h00, "R11");
      rd(A_CMD, 1'b0, "R1");
      rd(A_STS, 1'b0, "R1");

      // R7: disabled events still store the data
      callback_en = 1'b1;
      wr(A_CMD, 8'h55, 1'b0, "R7");
      callback_en = 1'b0;
      wr(A_CMD, 8'h56, 1'b0, "R7");
      rd(A_CMD, 1'b0, "R2");

      // R8: status register writes never raise an event
      apm_irq_en = 1'b1;
      wr(A_STS, 8'hA5, 1'b0, "R8");
      callback_en = 1'b1;
      wr(A_STS, 8'h3C, 1'b0, "R8");
      callback_en = 1'b0;
      rd(A_STS, 1'b0, "R2");

      // R3 / R11: other addresses not claimed
      rd(16'h0080, 1'b0, "R3");
      rd(16'h01B2, 1'b0, "R11");
      wr(16'h00B4, 8'hEE, 1'b0, "R3");

      // R4: secondary path ignored
      apm_irq_en = 1'b1;
      wr(A_CMD, 8'hFF, 1'b1, "R4");
      wr(A_STS, 8'hFF, 1'b1, "R4");
      rd(A_CMD, 1'b1, "R4");
      rd(A_CMD, 1'b0, "R4");
      rd(A_STS, 1'b0, "R4");

      // R5: management route, held until cleared (R9)
      wr(A_CMD, 8'h01, 1'b0, "R5");
      rd(A_CMD, 1'b0, "R2");
      idle(4, "R9");
      clr(1'b0, 8'h00, "R9");
      idle(2, "R9");

      // R6: callback route
      callback_en = 1'b1;
      wr(A_CMD, 8'h02, 1'b0, "R6");
      idle(3, "R9");
      clr(1'b0, 8'h00, "R9");

      // R10: event during clear wins, switching routes
      wr(A_CMD, 8'h03, 1'b0, "R6");
      callback_en = 1'b0;
      clr(1'b1, 8'h04, "R10");
      rd(A_CMD, 1'b0, "R10");
      clr(1'b0, 8'h00, "R9");

      // R7 again with callback set after clear
      apm_irq_en = 1'b0;
      callback_en = 1'b1;
      wr(A_CMD, 8'h77, 1'b0, "R7");
      rd(A_CMD, 1'b0, "R7");

      step();
      step();
      wait (q.size() == 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule